// File: doc/BRIEF.md
# UART Receive Queue with Status Word

This block sits between a UART's serial deserialiser and the register bank that a bus decoder exposes. Each received byte, together with its parity and framing flags, is stored in a small ring of entries. A read strobe on the receive data register takes the oldest entry off. Alongside the data path the block keeps a packed status word, a data-ready flag and a sticky error status nibble. It also emits a one-cycle error event that an interrupt collector can latch.

A three-bit control word selects the mode. With queueing turned off, a single holding register replaces the ring: every byte overwrites it, and a read empties it. With queueing turned on, the ring buffers up to `DEPTH` bytes. A read of an empty ring returns zero and flags an error; it never stalls. A break condition from the receiver is stored as a zero byte. The control word also carries two flush bits, one for the receive ring and one for the transmit side. Each stays set for exactly one cycle and then clears itself. The transmit side's level and full flag are passed into the status word unchanged.

Top module: `uart_rxq`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0 (queueing off), the status word reads 0 when tx_level and tx_full are 0, and data_ready, err_stat and err_evt are all 0.
- R2: With control bit 0 (enable) set, bytes are returned on rd_data in the order they arrived, and status bits [7:0] give the number of stored bytes.
- R3: When DEPTH (default 16) bytes are stored, status bit 8 is 1 and status bits [7:0] read 0. A byte arriving while full is dropped, sets err_stat bit 0 (overrun) and pulses err_evt in the next cycle.
- R4: With queueing on, a read of an empty ring returns 0, leaves the count at 0 and pulses err_evt in the next cycle.
- R5: With queueing on, data_ready is 1 while at least one byte is stored. After a read it stays 1 unless that read emptied the ring.
- R6: With queueing off, an arriving byte goes into a holding register and sets data_ready. A read returns that byte and clears data_ready. A second byte that arrives before the read overwrites the first and sets err_stat bit 0.
- R7: A break pulse (rx_break) stores a 0x00 byte and sets err_stat bit 3. rx_valid and rx_break are never high together.
- R8: err_stat holds overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3). A cycle with est_rd high clears it to zero, except for any bit that is set in that same cycle.
- R9: Status bit 9 is 1 while any stored byte arrived with a parity error, a framing error or as a break. It returns to 0 once those bytes have been read.
- R10: Writing control bit 1 makes that bit read 1 for one cycle; at the next edge the receive ring is emptied and the bit reads 0. Writing control bit 2 makes that bit and tx_flush high for exactly one cycle.
- R11: Status bits [23:16] equal tx_level and status bit 24 equals tx_full.
- R12: A push and a read in the same cycle on a ring that is neither empty nor full leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control value: bit 0 enable, bit 1 receive flush, bit 2 transmit flush |
| ctl_q | output | 3 | Current control word |
| tx_flush | output | 1 | One-cycle transmit flush request |
| rx_valid | input | 1 | Received byte strobe from the deserialiser |
| rx_data | input | DW (8) | Received byte |
| rx_perr | input | 1 | Parity error for the byte on rx_data |
| rx_ferr | input | 1 | Framing error for the byte on rx_data |
| rx_break | input | 1 | Break detected (pushes a zero byte) |
| rd_req | input | 1 | Receive data register read strobe |
| rd_data | output | DW (8) | Data returned for the read in the same cycle |
| est_rd | input | 1 | Error status read strobe (read-to-clear) |
| err_stat | output | 4 | Error status: overrun, parity, frame, break |
| tx_level | input | 8 | Transmit side occupancy |
| tx_full | input | 1 | Transmit side full |
| fifo_stat | output | 32 | Packed status word |
| data_ready | output | 1 | Receive data available |
| err_evt | output | 1 | One-cycle error interrupt source event |

## Verification
The checks assume the deserialiser never raises rx_valid and rx_break in the same cycle, and one property states this directly. They also assume that no push or read coincides with the cycle in which a receive flush takes effect. The stimulus drives each strobe for a single cycle between clock falls. It leaves at least one idle cycle after each control write before touching the data path, and it issues simultaneous push and read only when the ring is neither empty nor full.

// File: rtl/uart_rxq_pkg.sv
// Package: shared bit positions and the error status type for the receive queue.
// Assumes: the control word is three bits wide and the error status is four bits wide.
package uart_rxq_pkg;

    localparam int unsigned CTL_BITS  = 3;
    localparam int unsigned CTL_EN    = 0;
    localparam int unsigned CTL_RXCLR = 1;
    localparam int unsigned CTL_TXCLR = 2;

    localparam int unsigned STAT_W    = 32;
    localparam int unsigned CNT_FLD_W = 8;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } err_bits_t;

endpackage

// File: rtl/rxq_store.sv
// Module: ring storage for received bytes, each with one error tag bit.
// Assumes: the caller never pushes when full or pops when empty; flush overrides push and pop.
module rxq_store #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_flag,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_flag,
    output logic [CW-1:0] count,
    output logic [CW-1:0] flag_count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW:0]   mem [DEPTH];
    logic [PW-1:0] wp, rp;

    // Wrap a pointer modulo the depth.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Entry write: store byte and tag at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= {push_flag, push_data};
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Count of stored entries carrying an error tag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) flag_count <= '0;
        else flag_count <= flag_count + CW'(push && push_flag) - CW'(pop && head_flag);
    end

    assign head_data = mem[rp][DW-1:0];
    assign head_flag = mem[rp][DW];

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count != CW'(DEPTH));
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
    p_push_pop_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush) |=> count == $past(count));
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && flag_count == '0));
    p_tag_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_count <= count);

endmodule

// File: rtl/rxq_errstat.sv
// Module: sticky error status nibble, cleared by a read strobe.
// Assumes: a bit set in the same cycle as the clearing read survives the read.
module rxq_errstat
    import uart_rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  err_bits_t set,
    output err_bits_t stat
);

    // Clear on read, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (clr ? err_bits_t'('0) : stat) | set;
    end

    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> stat == '0);
    p_set_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set.ovr |=> stat.ovr);
    p_break_recorded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set.brk |=> stat.brk);

endmodule

// File: rtl/uart_rxq.sv
// Module: UART receive queue top; control word, holding register, status word and error events.
// Assumes: rx_valid and rx_break are exclusive; DEPTH is at most 255 so the count fits its field.
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [2:0]    ctl_wdata,
    output logic [2:0]    ctl_q,
    output logic          tx_flush,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    input  logic          rx_break,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    input  logic          est_rd,
    output logic [3:0]    err_stat,
    input  logic [7:0]    tx_level,
    input  logic          tx_full,
    output logic [31:0]   fifo_stat,
    output logic          data_ready,
    output logic          err_evt
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          en, flush;
    logic          push_req, push_flag;
    logic [DW-1:0] push_byte;
    logic          full, empty;
    logic          q_push, q_drop, q_pop, empty_rd, hold_ovr;
    logic [DW-1:0] head_data, hold_q;
    logic          head_flag, hold_full;
    logic [CW-1:0] count, flag_count;
    err_bits_t     err_set, err_q;

    // Control word: enable persists, flush bits last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
        else begin
            ctl_q[CTL_RXCLR] <= 1'b0;
            ctl_q[CTL_TXCLR] <= 1'b0;
        end
    end

    assign en       = ctl_q[CTL_EN];
    assign flush    = ctl_q[CTL_RXCLR];
    assign tx_flush = ctl_q[CTL_TXCLR];

    // Incoming byte selection: a break enters as a zero byte with its tag set.
    assign push_req  = rx_valid | rx_break;
    assign push_byte = rx_break ? '0 : rx_data;
    assign push_flag = rx_break | (rx_valid & (rx_perr | rx_ferr));

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Queue-mode strobes.
    assign q_push   = en & push_req & ~flush & ~full;
    assign q_drop   = en & push_req & ~flush & full;
    assign q_pop    = en & rd_req & ~flush & ~empty;
    assign empty_rd = en & rd_req & empty;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .push       (q_push),
        .push_data  (push_byte),
        .push_flag  (push_flag),
        .pop        (q_pop),
        .head_data  (head_data),
        .head_flag  (head_flag),
        .count      (count),
        .flag_count (flag_count)
    );

    // Holding register used while queueing is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (!en) begin
            if (push_req) begin
                hold_q    <= push_byte;
                hold_full <= 1'b1;
            end else if (rd_req) begin
                hold_full <= 1'b0;
            end
        end
    end

    assign hold_ovr = ~en & push_req & hold_full & ~rd_req;

    // Error status events.
    always_comb begin
        err_set     = '0;
        err_set.ovr = q_drop | hold_ovr;
        err_set.par = rx_valid & ~rx_break & rx_perr;
        err_set.frm = rx_valid & ~rx_break & rx_ferr;
        err_set.brk = rx_break;
    end

    rxq_errstat u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (est_rd),
        .set   (err_set),
        .stat  (err_q)
    );

    assign err_stat = err_q;

    // Error interrupt source event, one cycle after the cause.
    always_ff @(posedge clk) begin
        if (!rst_n) err_evt <= 1'b0;
        else        err_evt <= q_drop | empty_rd | hold_ovr;
    end

    // Read data and ready flag per mode.
    assign rd_data    = en ? (empty ? '0 : head_data) : hold_q;
    assign data_ready = en ? ~empty : hold_full;

    // Packed status word.
    always_comb begin
        fifo_stat        = '0;
        fifo_stat[7:0]   = full ? 8'd0 : CNT_FLD_W'(count);
        fifo_stat[8]     = full;
        fifo_stat[9]     = (flag_count != '0);
        fifo_stat[23:16] = tx_level;
        fifo_stat[24]    = tx_full;
    end

    p_inputs_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_break));
    p_empty_read_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_req && count == '0) |=> err_evt);
    p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push_req && !flush && count == CW'(DEPTH)) |=> (err_evt && err_stat[0]));
    p_ready_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_req && count == CW'(1) && !push_req && !ctl_wr && !flush) |=> !data_ready);
    p_hold_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && rd_req && !push_req && !ctl_wr) |=> !data_ready);
    p_flush_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[CTL_RXCLR] && !ctl_wr) |=> !ctl_q[CTL_RXCLR]);
    p_txflush_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !ctl_wr) |=> !tx_flush);

endmodule

// File: tb/tb_uart_rxq.sv
`timescale 1ns/1ps
module tb_uart_rxq;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic [2:0]  ctl_q;
    logic        tx_flush;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_perr = 1'b0;
    logic        rx_ferr = 1'b0;
    logic        rx_break = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_data;
    logic        est_rd = 1'b0;
    logic [3:0]  err_stat;
    logic [7:0]  tx_level = '0;
    logic        tx_full = 1'b0;
    logic [31:0] fifo_stat;
    logic        data_ready;
    logic        err_evt;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   fifo_mode = 1'b0;
    bit   done = 1'b0;
    logic [7:0] sb [$];

    always #2.5 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH), .DW(8)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .tx_flush(tx_flush), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break), .rd_req(rd_req),
        .rd_data(rd_data), .est_rd(est_rd), .err_stat(err_stat), .tx_level(tx_level),
        .tx_full(tx_full), .fifo_stat(fifo_stat), .data_ready(data_ready), .err_evt(err_evt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Driver: model the expected contents of the ring or holding register.
    task automatic model_push(input logic [7:0] b);
        if (fifo_mode) begin
            if (sb.size() < DEPTH) sb.push_back(b);
        end else begin
            sb.delete();
            sb.push_back(b);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit pe, input bit fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_perr = pe; rx_ferr = fe;
        model_push(b);
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk);
        rx_break = 1'b1;
        model_push(8'h00);
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic push_rd(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rd_req = 1'b1;
        model_push(b);
        @(negedge clk);
        rx_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic ctl(input logic [2:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic est_clear();
        @(negedge clk);
        est_rd = 1'b1;
        @(negedge clk);
        est_rd = 1'b0;
    endtask

    // Monitor: compare each read against the scoreboard head.
    always @(negedge clk) begin
        #1;
        if (rd_req && rst_n) begin
            logic [7:0] exp;
            exp = (sb.size() > 0) ? sb[0] : 8'h00;
            chk(rd_data == exp, fifo_mode ? (sb.size() > 0 ? "R2 order" : "R4 empty read")
                                          : "R6 hold read", {24'h0, rd_data}, {24'h0, exp});
            if (sb.size() > 0) void'(sb.pop_front());
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ctl_q == 3'd0, "R1 ctl", ctl_q, 0);
        chk(fifo_stat == 32'd0, "R1 stat", fifo_stat, 0);
        chk(data_ready == 1'b0, "R1 ready", data_ready, 0);
        chk(err_stat == 4'd0 && err_evt == 1'b0, "R1 err", {err_evt, err_stat}, 0);

        // R6 holding register mode
        fifo_mode = 1'b0;
        push(8'h41, 0, 0);
        chk(data_ready == 1'b1, "R6 ready set", data_ready, 1);
        rd();
        chk(data_ready == 1'b0, "R6 ready cleared", data_ready, 0);
        push(8'h42, 0, 0);
        push(8'h43, 0, 0);
        chk(err_stat[0] == 1'b1, "R6 overwrite overrun", err_stat, 1);
        rd();
        est_clear();
        chk(err_stat == 4'd0, "R8 clear on read", err_stat, 0);

        // R2/R5 queue mode ordering and ready
        ctl(3'b001);
        fifo_mode = 1'b1;
        chk(ctl_q == 3'b001, "R10 enable", ctl_q, 1);
        push(8'h10, 0, 0); push(8'h11, 0, 0); push(8'h12, 0, 0);
        chk(fifo_stat[7:0] == 8'd3, "R2 count", fifo_stat[7:0], 3);
        chk(data_ready == 1'b1, "R5 ready", data_ready, 1);
        rd(); rd();
        chk(data_ready == 1'b1, "R5 ready held", data_ready, 1);
        rd();
        chk(data_ready == 1'b0, "R5 ready cleared on empty", data_ready, 0);

        // R4 empty read
        rd();
        chk(err_evt == 1'b1, "R4 event", err_evt, 1);
        chk(fifo_stat[7:0] == 8'd0, "R4 count stays 0", fifo_stat[7:0], 0);

        // R3 full and overflow
        for (int i = 0; i < DEPTH; i++) push(8'h20 + 8'(i), 0, 0);
        chk(fifo_stat[8] == 1'b1 && fifo_stat[7:0] == 8'd0, "R3 full reads zero count",
            fifo_stat[8:0], 32'h100);
        push(8'hEE, 0, 0);
        chk(err_evt == 1'b1, "R3 drop event", err_evt, 1);
        chk(err_stat == 4'b0001, "R3 overrun bit", err_stat, 1);
        chk(fifo_stat[8] == 1'b1, "R3 still full", fifo_stat[8], 1);
        est_clear();
        chk(err_stat == 4'd0, "R8 cleared", err_stat, 0);

        // R12 simultaneous push and read
        rd();
        chk(fifo_stat[7:0] == 8'd15, "R12 before", fifo_stat[7:0], 15);
        push_rd(8'h99);
        chk(fifo_stat[7:0] == 8'd15, "R12 count unchanged", fifo_stat[7:0], 15);
        for (int i = 0; i < 15; i++) rd();
        chk(data_ready == 1'b0, "R5 drained", data_ready, 0);

        // R9/R8 error tags and status bits
        push(8'h55, 1, 0);
        push(8'h56, 0, 0);
        chk(fifo_stat[9] == 1'b1, "R9 tag set", fifo_stat[9], 1);
        chk(err_stat == 4'b0010, "R8 parity bit", err_stat, 2);
        rd();
        chk(fifo_stat[9] == 1'b0, "R9 tag cleared", fifo_stat[9], 0);
        rd();
        @(negedge clk);
        est_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h77; rx_ferr = 1'b1;
        model_push(8'h77);
        @(negedge clk);
        est_rd = 1'b0; rx_valid = 1'b0; rx_ferr = 1'b0;
        chk(err_stat == 4'b0100, "R8 set survives read", err_stat, 4);
        chk(fifo_stat[9] == 1'b1, "R9 frame tag", fifo_stat[9], 1);
        rd();
        est_clear();

        // R7 break
        brk();
        chk(fifo_stat[7:0] == 8'd1, "R7 zero byte stored", fifo_stat[7:0], 1);
        chk(err_stat[3] == 1'b1, "R7 break bit", err_stat, 8);
        rd();
        est_clear();

        // R10 receive flush
        push(8'h61, 0, 0); push(8'h62, 0, 0);
        ctl(3'b011);
        chk(ctl_q == 3'b011, "R10 flush bit visible", ctl_q, 3);
        sb.delete();
        @(negedge clk);
        chk(ctl_q == 3'b001, "R10 flush bit cleared", ctl_q, 1);
        chk(fifo_stat[7:0] == 8'd0 && data_ready == 1'b0, "R10 ring emptied",
            {data_ready, fifo_stat[7:0]}, 0);

        // R10 transmit flush pulse
        ctl(3'b101);
        chk(tx_flush == 1'b1 && ctl_q == 3'b101, "R10 tx flush high", {tx_flush, ctl_q}, 4'hD);
        @(negedge clk);
        chk(tx_flush == 1'b0 && ctl_q == 3'b001, "R10 tx flush cleared", {tx_flush, ctl_q}, 1);

        // R11 transmit fields
        tx_level = 8'h3C; tx_full = 1'b1;
        #1;
        chk(fifo_stat[23:16] == 8'h3C && fifo_stat[24] == 1'b1, "R11 tx fields",
            fifo_stat[24:16], 32'h13C);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule